// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed 16-bit two's-complement operands and returns the full 32-bit signed product. It is iterative. After a start request is accepted, it retires two multiplier bits per clock. A recoder looks at each overlapping group of three multiplier bits and reduces it to three control bits: negate, zero and double. These bits select a partial product of 0, ±b or ±2b. The selected value is added into an accumulator, and the accumulator shifts right arithmetically by two bits on every step.

The host drives the operands and pulses `start_i` while the block is idle. `busy_o` stays high for the eight recode/accumulate steps. `done_o` then pulses for one cycle, and the product appears on `product_o`. The product stays on `product_o` until the next accepted start completes.

Top module: `booth_mul_r4`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `busy_o`, `done_o` and `product_o` are all zero.
- R2: A `start_i` sampled high at a rising edge while `busy_o` is low captures `mcand_i` and `mplier_i`, and `busy_o` is high after that edge.
- R3: Each step recodes the triplet {multiplier bit i+1, bit i, bit i-1}. The value of bit i-1 below bit 0 is taken as 0. The triplets map to partial products as follows: 000 and 111 give 0; 001 and 010 give +b; 011 gives +2b; 100 gives -2b; 101 and 110 give -b.
- R4: The negate control equals bit i+1 of the triplet. Zero is set only for 000 and 111, and zero overrides negate. Double is set only for 011 and 100, so zero and double are never set together. 2b is b shifted left one bit. -x is formed as the inverse of x with a carry-in of 1.
- R5: `done_o` rises exactly at the eighth rising edge after the accepting edge. It stays high for one cycle, and `busy_o` falls at that same edge.
- R6: When `done_o` is high, `product_o` equals the signed 32-bit product of the captured operands.
- R7: The operand pairs -32768 × -32768 (result 0x40000000) and -32768 × 32767 (result 0xC0008000) give correct products.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running product and its timing are unaffected.
- R9: While `busy_o` is low, `product_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only while idle |
| mcand_i | input | 16 | Signed multiplicand b |
| mplier_i | input | 16 | Signed multiplier |
| busy_o | output | 1 | High during the eight steps |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 32 | Signed product, held between operations |

## Verification
The assertions assume that `start_i` is a synchronous pulse. They also assume that `mcand_i` and `mplier_i` are only meaningful in the cycle that `start_i` is high. Nothing else about the inputs is assumed, because the block is meant to tolerate `start_i` at any time. The bench drives inputs only on falling clock edges. It holds `start_i` for exactly one cycle per operation, except in the R8 cases, where a second pulse with different operands is injected in the middle of a run. The operand sweep covers every low-byte multiplier pattern and a set of extreme and alternating values crossed with each other. A pseudo-random stream fills the rest of the operand space.

// File: rtl/booth_pkg.sv
package booth_pkg;
  localparam int OP_W   = 16;
  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = OP_W + 2;   // room for +-2b
  localparam int STEPS  = OP_W / 2;
  localparam int CNT_W  = $clog2(STEPS);

  typedef struct packed {
    logic neg;
    logic zero;
    logic two;
  } booth_ctrl_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0]  trip_i,
  output booth_ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o.neg  = trip_i[2];
    ctrl_o.zero = (trip_i == 3'b000) || (trip_i == 3'b111);
    ctrl_o.two  = (trip_i == 3'b011) || (trip_i == 3'b100);
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int IN_W  = OP_W,
  parameter int OUT_W = ACC_W
) (
  input  logic [IN_W-1:0]  mcand_i,
  input  booth_ctrl_t      ctrl_i,
  output logic [OUT_W-1:0] pp_o,
  output logic             cin_o
);
  localparam int EXT_W = OUT_W - IN_W;

  logic [OUT_W-1:0] ext, mag;

  assign ext = {{EXT_W{mcand_i[IN_W-1]}}, mcand_i};
  assign mag = ctrl_i.two ? (ext << 1) : ext;  // 2b by wiring only

  always_comb begin
    if (ctrl_i.zero) begin
      pp_o  = '0;
      cin_o = 1'b0;
    end else begin
      pp_o  = ctrl_i.neg ? ~mag : mag;
      cin_o = ctrl_i.neg;
    end
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
  import booth_pkg::*;
#(
  parameter int N_STEPS = STEPS,
  parameter int C_W     = CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);
  logic [C_W-1:0] cnt_q;

  assign accept_o = start_i && !busy_o;
  assign last_o   = busy_o && (cnt_q == C_W'(N_STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= last_o;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) busy_o <= 1'b0;
      end
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o || $past(start_i));
  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/booth_mul_r4.sv
module booth_mul_r4
  import booth_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PROD_W-1:0] product_o
);
  localparam int COMB_W = ACC_W + OP_W;

  logic              accept, last;
  logic [ACC_W-1:0]  hi_q, pp, sum;
  logic [OP_W-1:0]   lo_q, mcand_q;
  logic              qm1_q, cin;
  booth_ctrl_t       ctrl;
  logic signed [COMB_W-1:0] comb, shifted;

  booth_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .last_o   (last),
    .done_o   (done_o)
  );

  booth_recoder u_rec (
    .trip_i (({lo_q[1:0], qm1_q})),
    .ctrl_o (ctrl)
  );

  booth_pp_gen u_pp (
    .mcand_i (mcand_q),
    .ctrl_i  (ctrl),
    .pp_o    (pp),
    .cin_o   (cin)
  );

  assign sum     = hi_q + pp + {{(ACC_W-1){1'b0}}, cin};
  assign comb    = {sum, lo_q};
  assign shifted = comb >>> 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      lo_q      <= '0;
      qm1_q     <= 1'b0;
      mcand_q   <= '0;
      product_o <= '0;
    end else if (accept) begin
      hi_q    <= '0;
      lo_q    <= mplier_i;
      qm1_q   <= 1'b0;           // bit below LSB is zero
      mcand_q <= mcand_i;
    end else if (busy_o) begin
      {hi_q, lo_q} <= shifted;
      qm1_q        <= lo_q[1];
      if (last) product_o <= shifted[PROD_W-1:0];
    end
  end

  p_zero_two_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(ctrl.zero && ctrl.two));
  p_zero_no_cin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl.zero) |-> (pp == '0) && !cin);
  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mcand_q));
  p_hold_product_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(product_o));
  p_first_trip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !qm1_q);
endmodule

// File: tb/tb_booth_mul_r4.sv
module tb_booth_mul_r4;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mcand_i = '0, mplier_i = '0;
  logic        busy_o, done_o;
  logic [31:0] product_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [15:0] corners [12];

  always #4 clk_i = ~clk_i;  // 125 MHz

  booth_mul_r4 dut (.*);

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    return 32'($signed(a) * $signed(b));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // one multiply; inj>0 injects a stray start with other operands at that cycle
  task automatic run_mul(input logic [15:0] a, input logic [15:0] b,
                         input string req, input int inj);
    int cyc;
    logic [31:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk_i);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    cyc = 0;
    while (1) begin
      @(negedge clk_i);
      cyc++;
      start_i = 1'b0;
      mcand_i = ~a; mplier_i = b ^ 16'h5a5a;
      if (cyc == 1) chk("R2 busy after accept", 32'(busy_o), 32'd1);
      if (inj > 0 && cyc == inj) start_i = 1'b1;
      if (done_o) break;
      if (cyc > 40) begin
        n_chk++; n_fail++;
        $display("FAIL R5: done never seen, actual none expected cycle 9");
        break;
      end
    end
    start_i = 1'b0;
    chk({req, " product"}, product_o, exp);
    chk("R5 latency", 32'(cyc), 32'd9);
    chk("R5 busy low at done", 32'(busy_o), 32'd0);
    @(negedge clk_i);
    chk("R5 done one cycle", 32'(done_o), 32'd0);
    chk("R9 product held", product_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    corners = '{16'h0000, 16'h0001, 16'hffff, 16'h0002, 16'hfffe, 16'h7fff,
                16'h8000, 16'h5555, 16'haaaa, 16'hf16a, 16'h9dae, 16'h8001};
    repeat (3) @(negedge clk_i);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    chk("R1 done in reset", 32'(done_o), 32'd0);
    chk("R1 product in reset", product_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    chk("R1 product after reset", product_o, 32'd0);

    // R7 corners
    run_mul(16'h8000, 16'h8000, "R7 min*min", 0);
    chk("R7 value min*min", product_o, 32'h4000_0000);
    run_mul(16'h8000, 16'h7fff, "R7 min*max", 0);
    chk("R7 value min*max", product_o, 32'hc000_8000);
    run_mul(16'h7fff, 16'h8000, "R7 max*min", 0);

    // R3/R4: every low-byte multiplier pattern, sign variants on high byte
    for (int m = 0; m < 256; m++) begin
      run_mul(16'h1234, 16'(m), "R3 low-byte trip", 0);
      run_mul(16'h8000, {8'hff, 8'(m)}, "R4 neg trip", 0);
    end

    // R6 corner cross product
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        run_mul(corners[i], corners[j], "R6 corner", 0);

    // R8 stray start during busy
    for (int k = 1; k < 8; k++)
      run_mul(16'h7fff - 16'(k), 16'h8000 + 16'(k), "R8 stray start", k);

    // R6 pseudo-random
    for (int r = 0; r < 1500; r++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      run_mul(rng[15:0], rng[31:16], "R6 random", 0);
    end

    // R9 idle hold with start low
    repeat (5) @(negedge clk_i);
    chk("R9 idle hold", product_o, ref_mul(rng[15:0], rng[31:16]));

    finish_run();
  end
endmodule